// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Engine

This block is the master-side timing engine for an open-drain, single-wire bus. One line carries both timing and data. The master starts every operation by pulling the line low. A bit is encoded by how long the line stays low. The slave answers by pulling the line low inside fixed windows after each falling edge the master creates.

On a start request the engine runs one of three operations:
- a bus reset with presence detection;
- a one-bit write slot;
- a one-bit read slot.

It drives a pull-down enable for the line and never drives the line high. It samples the line through a two-flop synchronizer. When the operation ends it raises a one-cycle done pulse and reports two results: whether a slave answered the reset, and the bit that was read.

All durations are counted in microseconds. The microsecond tick comes from a clock-frequency parameter. Byte assembly, addressing, CRC and strong pull-up control are left to the logic around the block.

Top module: `sw_slot_engine`

## Requirements
- R1: After reset the pull-down is released, and `busy`, `done`, `present` and `rd_bit` are all 0.
- R2: A reset operation (`op` = 2'b00) pulls the line low for exactly 480 us, then releases it. `done` rises 960 us after the accepting clock edge.
- R3: During a reset operation the engine samples the synchronized line 70 us after release. A low level there sets `present` to 1.
- R4: If the line is high at the presence sample point, `present` is 0. This covers both a silent bus and a slave whose pulse starts after the sample point.
- R5: A write with `wr_bit` = 1 (`op` = 2'b01) pulls the line low for 6 us. `done` comes 72 us after acceptance: a 70 us slot plus 2 us of recovery.
- R6: A write with `wr_bit` = 0 pulls the line low for 60 us, with the same 72 us total.
- R7: A read (`op` = 2'b10, and 2'b11 behaves the same) pulls the line low for 2 us. It samples the synchronized line 12 us after acceptance. `rd_bit` becomes 1 for a high line and 0 for a low line, and the total is 72 us.
- R8: Before `done`, the line is released for at least 2 us. Whenever the engine is idle, the pull-down is off.
- R9: A start request while `busy` is 1 is ignored: the running operation keeps its timing and no extra operation follows.
- R10: `done` lasts one clock cycle. `present` changes only at a reset's sample point and `rd_bit` only at a read's sample point. A write leaves both unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; frequency given by `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an operation; accepted only when idle |
| op | input | 2 | 00 reset, 01 write, 10/11 read |
| wr_bit | input | 1 | Bit to send in a write slot |
| line_in | input | 1 | Raw level of the bus line |
| line_pull | output | 1 | 1 = pull the line low, 0 = release |
| busy | output | 1 | An operation is running |
| done | output | 1 | One-cycle pulse when an operation ends |
| present | output | 1 | A slave answered the last reset |
| rd_bit | output | 1 | Bit captured by the last read |

## Verification
The checker assumes that `start` is a synchronous request, that `op` and `wr_bit` are valid in the cycle it is seen, and that nothing but `start` from idle can begin a slot. The slave model in the bench changes the line only on the falling clock edge. Its windows sit many microseconds away from each sample point, so the synchronizer delay never decides a result, except in the one deliberate late-edge case. Spurious start pulses are sent only in the middle of a busy slot, where the properties claim they are ignored.

// File: rtl/sw_pkg.sv
package sw_pkg;
    typedef enum logic [1:0] {
        OP_RESET = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } sw_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sw_state_e;
endpackage

// File: rtl/sw_us_tick.sv
module sw_us_tick #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int DIV = (CLK_HZ / 1_000_000 < 2) ? 2 : CLK_HZ / 1_000_000;
    localparam int CW  = $clog2(DIV);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == CW'(DIV - 1));

    always_comb begin
        if (restart || tick) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sw_sync.sv
module sw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] ff_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) ff_q[0] <= 1'b1;
                    else        ff_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) ff_q[i] <= 1'b1;
                    else        ff_q[i] <= ff_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = ff_q[STAGES-1];
endmodule

// File: rtl/sw_slot_fsm.sv
module sw_slot_fsm
    import sw_pkg::*;
#(
    parameter int W1_LOW_US   = 6,
    parameter int W0_LOW_US   = 60,
    parameter int RD_LOW_US   = 2,
    parameter int RD_SAMP_US  = 12,
    parameter int SLOT_US     = 70,
    parameter int REC_US      = 2,
    parameter int RST_LOW_US  = 480,
    parameter int RST_WAIT_US = 480,
    parameter int PRES_SAMP_US = 70
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic [1:0] op,
    input  logic       wr_bit,
    input  logic       line_s,
    output logic       accept,
    output logic       line_pull,
    output logic       busy,
    output logic       done,
    output logic       present,
    output logic       rd_bit
);
    localparam int SLOT_END = SLOT_US + REC_US;
    localparam int RST_END  = RST_LOW_US + RST_WAIT_US;
    localparam int MAX_END  = (RST_END > SLOT_END) ? RST_END : SLOT_END;
    localparam int USW      = $clog2(MAX_END + 1);

    typedef struct packed {
        sw_state_e      st;
        sw_op_e         op;
        logic           wbit;
        logic [USW-1:0] us;
        logic           pull;
        logic           done;
        logic           pres;
        logic           rbit;
    } fsm_t;

    fsm_t q, d;

    function automatic logic [USW-1:0] low_len(sw_op_e o, logic b);
        case (o)
            OP_RESET: return USW'(RST_LOW_US);
            OP_WRITE: return b ? USW'(W1_LOW_US) : USW'(W0_LOW_US);
            default:  return USW'(RD_LOW_US);
        endcase
    endfunction

    function automatic logic [USW-1:0] samp_at(sw_op_e o);
        return (o == OP_RESET) ? USW'(RST_LOW_US + PRES_SAMP_US) : USW'(RD_SAMP_US);
    endfunction

    function automatic logic [USW-1:0] end_at(sw_op_e o);
        return (o == OP_RESET) ? USW'(RST_END) : USW'(SLOT_END);
    endfunction

    assign accept = (q.st == ST_IDLE) && start;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.st == ST_IDLE) begin
            if (start) begin
                d.st   = ST_RUN;
                d.op   = (op == 2'b00) ? OP_RESET : (op == 2'b01) ? OP_WRITE : OP_READ;
                d.wbit = wr_bit;
                d.us   = '0;
            end
        end else if (tick) begin
            d.us = q.us + 1'b1;
            if (d.us == samp_at(q.op)) begin
                if (q.op == OP_RESET)     d.pres = ~line_s;
                else if (q.op == OP_READ) d.rbit = line_s;
            end
            if (d.us == end_at(q.op)) begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end
        end
        d.pull = (d.st == ST_RUN) && (d.us < low_len(d.op, d.wbit));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, op: OP_RESET, wbit: 1'b0, us: '0,
                   pull: 1'b0, done: 1'b0, pres: 1'b0, rbit: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign line_pull = q.pull;
    assign busy      = (q.st == ST_RUN);
    assign done      = q.done;
    assign present   = q.pres;
    assign rd_bit    = q.rbit;
endmodule

// File: rtl/sw_slot_engine.sv
module sw_slot_engine #(
    parameter int CLK_HZ      = 50_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] op,
    input  logic       wr_bit,
    input  logic       line_in,
    output logic       line_pull,
    output logic       busy,
    output logic       done,
    output logic       present,
    output logic       rd_bit
);
    logic tick, accept, line_s;

    sw_us_tick #(.CLK_HZ(CLK_HZ)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(accept), .tick(tick)
    );

    sw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(line_in), .dout(line_s)
    );

    sw_slot_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .op(op),
        .wr_bit(wr_bit), .line_s(line_s), .accept(accept),
        .line_pull(line_pull), .busy(busy), .done(done),
        .present(present), .rd_bit(rd_bit)
    );
endmodule

// File: rtl/sw_slot_engine_chk.sv
module sw_slot_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic line_pull,
    input logic busy,
    input logic done,
    input logic present,
    input logic rd_bit
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line_pull); // R8

    AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !$past(line_pull)); // R8

    AST_BUSY_ONLY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R9

    AST_PULL_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(line_pull) && !$past(busy)) |-> $past(start)); // R9

    AST_RESULTS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> ($stable(present) && $stable(rd_bit))); // R10
endmodule

bind sw_slot_engine sw_slot_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .line_pull(line_pull),
    .busy(busy), .done(done), .present(present), .rd_bit(rd_bit)
);

// File: tb/sw_slot_engine_test.sv
module sw_slot_engine_test;
    localparam int TB_HZ = 10_000_000;
    localparam int DIV   = TB_HZ / 1_000_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] op = 2'b00;
    logic wr_bit = 1'b0;
    logic line_pull, busy, done, present, rd_bit;
    logic slave_low = 1'b0;
    logic line_in;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int win_from = -1;
    int win_to = -1;
    int stray_at = -1;

    always #10 clk = ~clk;

    assign line_in = ~(line_pull | slave_low);

    sw_slot_engine #(.CLK_HZ(TB_HZ)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wr_bit(wr_bit),
        .line_in(line_in), .line_pull(line_pull), .busy(busy), .done(done),
        .present(present), .rd_bit(rd_bit)
    );

    always @(negedge clk) slave_low <= (cyc >= win_from) && (cyc < win_to);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] o, input logic b,
                          output int low_c, output int tot_c, output int rel_c);
        low_c = 0; rel_c = 0; tot_c = -1;
        @(negedge clk);
        start = 1'b1; op = o; wr_bit = b;
        @(posedge clk);
        cyc = 0;
        forever begin
            @(negedge clk);
            start = (cyc == stray_at);
            if (done) begin tot_c = cyc; break; end
            if (line_pull) begin low_c++; rel_c = 0; end
            else rel_c++;
            if (cyc > 20000) break;
            @(posedge clk);
            cyc++;
        end
        start = 1'b0;
        @(negedge clk);
        check("R10 done pulse", int'(done), 0);
        win_from = -1; win_to = -1; stray_at = -1;
        cyc = 0;
    endtask

    task automatic t_reset_state();
        check("R1 pull", int'(line_pull), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 present", int'(present), 0);
        check("R1 rd_bit", int'(rd_bit), 0);
    endtask

    task automatic t_reset_with_slave();
        int l, t, r;
        win_from = 4800 + 200; win_to = 4800 + 1200;
        run_op(2'b00, 1'b0, l, t, r);
        check("R2 low time", l, 480 * DIV);
        check("R2 total", t, 960 * DIV);
        check("R3 present", int'(present), 1);
    endtask

    task automatic t_reset_no_slave();
        int l, t, r;
        run_op(2'b00, 1'b0, l, t, r);
        check("R4 silent present", int'(present), 0);
    endtask

    task automatic t_reset_late_slave();
        int l, t, r;
        win_from = 4800 + 750; win_to = 4800 + 1500;
        run_op(2'b00, 1'b0, l, t, r);
        check("R4 late present", int'(present), 0);
    endtask

    task automatic t_write(input logic b);
        int l, t, r;
        int p0, r0;
        p0 = int'(present); r0 = int'(rd_bit);
        run_op(2'b01, b, l, t, r);
        if (b) check("R5 w1 low", l, 6 * DIV);
        else   check("R6 w0 low", l, 60 * DIV);
        check(b ? "R5 w1 total" : "R6 w0 total", t, 72 * DIV);
        check("R8 recovery", int'(r >= 2 * DIV), 1);
        check("R10 present held", int'(present), p0);
        check("R10 rd_bit held", int'(rd_bit), r0);
    endtask

    task automatic t_read(input logic [1:0] o, input int from, input int exp_bit,
                          input int stray);
        int l, t, r;
        if (from >= 0) begin win_from = from; win_to = 300; end
        stray_at = stray;
        run_op(o, 1'b0, l, t, r);
        check("R7 read low", l, 2 * DIV);
        check(stray >= 0 ? "R9 total with stray start" : "R7 total", t, 72 * DIV);
        check("R7 read bit", int'(rd_bit), exp_bit);
        check("R8 recovery", int'(r >= 2 * DIV), 1);
        repeat (3) @(negedge clk);
        check("R9 no extra op", int'(busy), 0);
    endtask

    int wd = 0;
    initial begin
        while (wd < 150_000) begin @(posedge clk); wd++; end
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected below 150000", wd);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset_with_slave();
        t_write(1'b1);
        t_reset_no_slave();
        t_reset_late_slave();
        t_read(2'b10, 15, 0, -1);
        t_write(1'b1);
        t_write(1'b0);
        t_read(2'b10, -1, 1, -1);
        t_read(2'b11, 130, 1, -1);
        t_read(2'b10, 15, 0, 300);
        t_read(2'b10, -1, 1, 100);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule